// File: doc/BRIEF.md
# Three-Digit Vacuum Fluorescent Scan Sender

This block runs in the system clock domain and refreshes a multiplexed vacuum fluorescent display through a serial shift-and-latch tube driver. The host supplies one anode pattern per digit and a 4-bit brightness value. The block drives four pins: serial data, serial clock, strobe and grid enable.

For each digit in turn, the block builds a 34-bit frame. The frame holds a one-hot grid field followed by that digit's 31 anode bits. The block shifts the frame out on the serial clock, pulses strobe so the driver latches the frame, and then holds the digit for a fixed dwell time. The three grids take turns, and the whole scan repeats without end.

Grid enable is low while a frame is shifted and while it is latched. During the dwell it is high for a share of the time set by the brightness value. New patterns and a new brightness value are taken only when a scan begins with the first digit. A scan therefore never mixes old and new data.

The controller is one state machine with seven states:
- SAMPLE: takes the inputs when the digit index is 0. Always goes to BUILD.
- BUILD: loads the frame register. Goes to CLK_LOW.
- CLK_LOW: goes to CLK_HIGH when its timer expires.
- CLK_HIGH: goes back to CLK_LOW for the next bit. After the last bit it goes to TAIL.
- TAIL: goes to LATCH when its timer expires.
- LATCH: goes to DWELL when its timer expires.
- DWELL: goes to SAMPLE when the dwell ends, advancing the digit.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ser_dout`, `ser_clk`, `ser_stb` and `grid_en` are all low. The first frame after reset belongs to digit 0.
- R2: Each frame has exactly 34 rising edges of `ser_clk`. Every high phase lasts exactly HALF_CYC system clocks. Every low phase between two bits of a frame lasts exactly HALF_CYC system clocks.
- R3: Frame positions are numbered 1 to 34, and position 1 is sent first. For digit k (0..2), position k+1 is 1 and the other two of positions 1..3 are 0. Position 4+j carries bit j of `digit_pat[k*31 +: 31]`, for j = 0..30.
- R4: `ser_dout` changes only while `ser_clk` is low. It is constant for the whole high phase, including the cycle in which `ser_clk` rises.
- R5: `ser_stb` is never high while `ser_clk` is high. It goes high only after the 34th bit, and only after `ser_clk` has been low for at least HALF_CYC clocks. Each pulse lasts exactly STB_CYC clocks.
- R6: Successive frames select digits 0, 1, 2, 0, 1, 2 and so on.
- R7: `grid_en` is low whenever `ser_clk` or `ser_stb` is high. It is high only during the dwell that follows a strobe.
- R8: Each dwell lasts 16*SLOT_CYC clocks. `grid_en` is high for exactly duty*SLOT_CYC clocks at the start of the dwell, so duty 0 keeps the grids dark. From the falling edge of strobe to the next rising edge of `ser_clk` is 16*SLOT_CYC + 2 + HALF_CYC clocks.
- R9: `digit_pat` and `duty` are sampled only when digit 0's frame is prepared. Changes made later in a scan do not affect frames or brightness until the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| digit_pat | input | NUM_GRIDS*NUM_ANODES | Anode patterns; digit k at bits k*NUM_ANODES upward |
| duty | input | 4 | Brightness, 0 (dark) to 15 |
| ser_dout | output | 1 | Serial frame data to the driver |
| ser_clk | output | 1 | Serial shift clock to the driver |
| ser_stb | output | 1 | Latch strobe to the driver |
| grid_en | output | 1 | Grid output enable to the driver |

## Verification
The bench rebuilds every frame from the serial pins and checks the bit order and the one-hot grid field against the patterns. A design that sent the frame in reverse, or misplaced the grid field, would light the wrong segments, and the frame comparison catches both. It also measures each high and low phase, each strobe width, and the gap up to the next frame. An off-by-one timer would shorten a pulse below the driver's minimum, and these measurements catch it.

The bench sweeps brightness at 0, 1 and 15, which catches a gate with a wrong comparison. It changes the inputs during the dwell of digit 0. A design that took the change at once would show torn scans, with a new pattern on digit 1 while digit 0 still shows the old one. A reset applied in the middle of shifting must force every pin low.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    typedef enum logic [2:0] {
        SC_SAMPLE,
        SC_BUILD,
        SC_CLK_LOW,
        SC_CLK_HIGH,
        SC_TAIL,
        SC_LATCH,
        SC_DWELL
    } scan_state_t;

    localparam int DUTY_W     = 4;
    localparam int DUTY_STEPS = 1 << DUTY_W;

endpackage

// File: rtl/vfd_frame_build.sv
module vfd_frame_build #(
    parameter int NUM_GRIDS  = 3,
    parameter int NUM_ANODES = 31,
    localparam int FRAME_W   = NUM_GRIDS + NUM_ANODES,
    localparam int GSEL_W    = (NUM_GRIDS > 1) ? $clog2(NUM_GRIDS) : 1
) (
    input  logic [GSEL_W-1:0]     dig,
    input  logic [NUM_ANODES-1:0] anodes,
    output logic [FRAME_W-1:0]    frame
);

    // MSB is the first bit on the wire (position 1)
    for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
        assign frame[FRAME_W-1-g] = (dig == GSEL_W'(g));
    end

    for (genvar j = 0; j < NUM_ANODES; j++) begin : g_anode
        assign frame[FRAME_W-1-NUM_GRIDS-j] = anodes[j];
    end

endmodule

// File: rtl/vfd_pace_timer.sv
module vfd_pace_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/vfd_dim_gate.sv
module vfd_dim_gate
    import vfd_scan_pkg::*;
#(
    parameter int SLOT_CYC = 1000,
    localparam int CYC_W   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DUTY_W-1:0] duty,
    output logic              en,
    output logic              done
);

    logic [CYC_W-1:0]  cyc;
    logic [DUTY_W-1:0] slot;
    logic              slot_end;

    assign slot_end = (cyc == CYC_W'(SLOT_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cyc  <= '0;
            slot <= '0;
        end else if (slot_end) begin
            cyc  <= '0;
            slot <= slot + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assign en   = run && (slot < duty);
    assign done = run && slot_end && (slot == DUTY_W'(DUTY_STEPS - 1));

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
    import vfd_scan_pkg::*;
#(
    parameter int NUM_GRIDS  = 3,
    parameter int NUM_ANODES = 31,
    parameter int HALF_CYC   = 50,
    parameter int STB_CYC    = 60,
    parameter int SLOT_CYC   = 1000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GRIDS*NUM_ANODES-1:0] digit_pat,
    input  logic [3:0]                      duty,
    output logic                            ser_dout,
    output logic                            ser_clk,
    output logic                            ser_stb,
    output logic                            grid_en
);

    localparam int FRAME_W = NUM_GRIDS + NUM_ANODES;
    localparam int GSEL_W  = (NUM_GRIDS > 1) ? $clog2(NUM_GRIDS) : 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int TMR_MAX = (HALF_CYC > STB_CYC) ? HALF_CYC : STB_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    scan_state_t state, state_nx;

    logic [GSEL_W-1:0]               dig;
    logic [NUM_GRIDS*NUM_ANODES-1:0] pat_q;
    logic [DUTY_W-1:0]               duty_q;
    logic [FRAME_W-1:0]              sh;
    logic [BIT_W-1:0]                bitcnt;
    logic [NUM_ANODES-1:0]           anode_sel;
    logic [FRAME_W-1:0]              frame_w;
    logic                            tmr_load;
    logic [TMR_W-1:0]                tmr_val;
    logic                            tmr_done;
    logic                            dim_en;
    logic                            dim_done;
    logic                            last_bit;

    assign anode_sel = pat_q[int'(dig)*NUM_ANODES +: NUM_ANODES];
    assign last_bit  = (bitcnt == BIT_W'(FRAME_W - 1));

    vfd_frame_build #(
        .NUM_GRIDS (NUM_GRIDS),
        .NUM_ANODES(NUM_ANODES)
    ) u_frame (
        .dig   (dig),
        .anodes(anode_sel),
        .frame (frame_w)
    );

    vfd_pace_timer #(.W(TMR_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .val  (tmr_val),
        .done (tmr_done)
    );

    vfd_dim_gate #(.SLOT_CYC(SLOT_CYC)) u_dim (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == SC_DWELL),
        .duty (duty_q),
        .en   (dim_en),
        .done (dim_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SC_SAMPLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(HALF_CYC - 1);
        unique case (state)
            SC_SAMPLE: state_nx = SC_BUILD;
            SC_BUILD: begin
                state_nx = SC_CLK_LOW;
                tmr_load = 1'b1;
            end
            SC_CLK_LOW: begin
                if (tmr_done) begin
                    state_nx = SC_CLK_HIGH;
                    tmr_load = 1'b1;
                end
            end
            SC_CLK_HIGH: begin
                if (tmr_done) begin
                    state_nx = last_bit ? SC_TAIL : SC_CLK_LOW;
                    tmr_load = 1'b1;
                end
            end
            SC_TAIL: begin
                if (tmr_done) begin
                    state_nx = SC_LATCH;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(STB_CYC - 1);
                end
            end
            SC_LATCH: begin
                if (tmr_done) state_nx = SC_DWELL;
            end
            SC_DWELL: begin
                if (dim_done) state_nx = SC_SAMPLE;
            end
            default: state_nx = SC_SAMPLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig    <= '0;
            pat_q  <= '0;
            duty_q <= '0;
            sh     <= '0;
            bitcnt <= '0;
        end else begin
            unique case (state)
                SC_SAMPLE: begin
                    if (dig == '0) begin
                        pat_q  <= digit_pat;
                        duty_q <= duty;
                    end
                end
                SC_BUILD: begin
                    sh     <= frame_w;
                    bitcnt <= '0;
                end
                SC_CLK_HIGH: begin
                    if (tmr_done && !last_bit) begin
                        sh     <= {sh[FRAME_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                SC_DWELL: begin
                    if (dim_done) begin
                        dig <= (dig == GSEL_W'(NUM_GRIDS - 1)) ? '0 : dig + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // pin outputs
    always_comb begin
        ser_clk  = (state == SC_CLK_HIGH);
        ser_stb  = (state == SC_LATCH);
        grid_en  = dim_en;
        ser_dout = 1'b0;
        unique case (state)
            SC_CLK_LOW, SC_CLK_HIGH, SC_TAIL: ser_dout = sh[FRAME_W-1];
            default: ser_dout = 1'b0;
        endcase
    end

endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
    parameter int NUM_GRIDS = 3,
    parameter int HALF_CYC  = 50,
    parameter int STB_CYC   = 60,
    localparam int GSEL_W   = (NUM_GRIDS > 1) ? $clog2(NUM_GRIDS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_dout,
    input logic              ser_clk,
    input logic              ser_stb,
    input logic              grid_en,
    input logic [GSEL_W-1:0] dig
);

    logic [31:0] hi_run, lo_run, stb_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lo_run  <= '0;
            stb_run <= '0;
        end else begin
            hi_run  <= ser_clk ? hi_run + 1 : '0;
            lo_run  <= ser_clk ? '0 : lo_run + 1;
            stb_run <= ser_stb ? stb_run + 1 : '0;
        end
    end

    a_r2_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> hi_run == HALF_CYC);

    a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> lo_run >= HALF_CYC);

    a_r4_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_dout));

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !ser_stb);

    a_r5_stb_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_stb) |-> stb_run == STB_CYC);

    a_r5_stb_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_stb) |-> lo_run >= HALF_CYC);

    a_r7_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk || ser_stb) |-> !grid_en);

    a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (dig != $past(dig)) |->
            dig == (($past(dig) == GSEL_W'(NUM_GRIDS - 1)) ? '0 : $past(dig) + 1'b1));

endmodule

bind vfd_scan_ctrl vfd_scan_chk #(
    .NUM_GRIDS(NUM_GRIDS),
    .HALF_CYC (HALF_CYC),
    .STB_CYC  (STB_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_dout(ser_dout),
    .ser_clk (ser_clk),
    .ser_stb (ser_stb),
    .grid_en (grid_en),
    .dig     (dig)
);

// File: tb/sim_vfd_scan_ctrl.sv
module sim_vfd_scan_ctrl;
    localparam int NG = 3, NA = 31, HC = 3, SC = 4, SL = 2, FW = NG + NA;
    localparam int NREC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NG*NA-1:0] pat = '0;
    logic [3:0] duty = '0;
    logic ser_dout, ser_clk, ser_stb, grid_en;

    always #5 clk = ~clk;

    vfd_scan_ctrl #(
        .NUM_GRIDS(NG), .NUM_ANODES(NA), .HALF_CYC(HC), .STB_CYC(SC), .SLOT_CYC(SL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .digit_pat(pat), .duty(duty),
        .ser_dout(ser_dout), .ser_clk(ser_clk), .ser_stb(ser_stb), .grid_en(grid_en)
    );

    int checks = 0, errors = 0;

    // pin monitor, samples on the falling system clock edge
    logic [FW-1:0] f_rx [NREC];
    int f_rise [NREC], f_hmin [NREC], f_hmax [NREC], f_lmin [NREC], f_stb [NREC];
    int f_en [NREC], f_gap [NREC];
    int nfrm, nfin, nrise, hmin, hmax, lmin, hi_run, lo_run, stb_run, en_acc, gap;
    int din_bad, ovl_bad, en_bad;
    logic [FW-1:0] rx;
    logic p_clk, p_stb, p_dout;

    always @(negedge clk) begin
        if (!rst_n) begin
            nfrm = 0; nfin = 0; nrise = 0; hmin = 1000000; hmax = 0; lmin = 1000000;
            hi_run = 0; lo_run = 0; stb_run = 0; en_acc = 0; gap = 0;
            din_bad = 0; ovl_bad = 0; en_bad = 0; rx = '0;
            p_clk = 1'b0; p_stb = 1'b0; p_dout = 1'b0;
        end else begin
            if (ser_clk && !p_clk) begin
                if (nrise == 0 && nfin < nfrm && nfin < NREC) begin
                    f_en[nfin] = en_acc; f_gap[nfin] = gap; nfin++;
                end
                if (nrise > 0 && lo_run < lmin) lmin = lo_run;
                rx = {rx[FW-2:0], ser_dout};
                nrise++;
            end
            if (!ser_clk && p_clk) begin
                if (hi_run < hmin) hmin = hi_run;
                if (hi_run > hmax) hmax = hi_run;
            end
            if (ser_clk) begin hi_run++; lo_run = 0; end
            else begin lo_run++; hi_run = 0; end
            if (ser_clk && p_clk && ser_dout != p_dout) din_bad++;
            if (ser_clk && ser_stb) ovl_bad++;
            if (grid_en && (ser_clk || ser_stb)) en_bad++;
            if (ser_stb) stb_run++;
            if (!ser_stb && p_stb) begin
                if (nfrm < NREC) begin
                    f_rx[nfrm] = rx; f_rise[nfrm] = nrise; f_hmin[nfrm] = hmin;
                    f_hmax[nfrm] = hmax; f_lmin[nfrm] = lmin; f_stb[nfrm] = stb_run;
                end
                nfrm++;
                rx = '0; nrise = 0; hmin = 1000000; hmax = 0; lmin = 1000000;
                stb_run = 0; en_acc = 0; gap = 0;
            end
            if (grid_en) en_acc++;
            gap++;
            p_clk = ser_clk; p_stb = ser_stb; p_dout = ser_dout;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] exp_frame(input int d, input logic [NA-1:0] an);
        logic [FW-1:0] f = '0;
        for (int g = 0; g < NG; g++) f[FW-1-g] = (g == d);
        for (int j = 0; j < NA; j++) f[FW-1-NG-j] = an[j];
        return f;
    endfunction

    task automatic start(input logic [NG*NA-1:0] p, input logic [3:0] d);
        rst_n = 1'b0; pat = p; duty = d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_fin(input int n);
        int t = 0;
        while (nfin < n && t < 20000) begin @(negedge clk); t++; end
        chk(nfin >= n, "R2 frame wait timeout", nfin, n);
    endtask

    task automatic check_frame(input int i, input logic [NG*NA-1:0] p, input int d);
        int k = i % NG;
        logic [FW-1:0] e = exp_frame(k, p[k*NA +: NA]);
        chk(f_rx[i] == e, "R3/R6 frame content", f_rx[i], e);
        chk(f_rise[i] == FW, "R2 rising edges per frame", f_rise[i], FW);
        chk(f_hmin[i] == HC && f_hmax[i] == HC, "R2 high phase", f_hmin[i], HC);
        chk(f_lmin[i] == HC, "R2 low phase", f_lmin[i], HC);
        chk(f_stb[i] == SC, "R5 strobe width", f_stb[i], SC);
        chk(f_en[i] == d * SL, "R8 enabled cycles", f_en[i], d * SL);
        chk(f_gap[i] == 16 * SL + 2 + HC, "R8 dwell gap", f_gap[i], 16 * SL + 2 + HC);
    endtask

    task automatic t_reset();
        start({NG*NA{1'b1}}, 4'd15);
        rst_n = 1'b0;
        @(negedge clk);
        chk({ser_dout, ser_clk, ser_stb, grid_en} == 4'b0, "R1 outputs in reset", {ser_dout, ser_clk, ser_stb, grid_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ser_dout, ser_clk, ser_stb, grid_en} == 4'b0, "R1 outputs after release", {ser_dout, ser_clk, ser_stb, grid_en}, 0);
        wait_fin(1);
        check_frame(0, pat, 15);
        while (!ser_clk) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({ser_dout, ser_clk, ser_stb, grid_en} == 4'b0, "R1 reset mid-shift", {ser_dout, ser_clk, ser_stb, grid_en}, 0);
    endtask

    task automatic t_basic();
        logic [NG*NA-1:0] p = {31'h2AAAAAAA, 31'h40000000, 31'h00000001};
        start(p, 4'd15);
        wait_fin(6);
        for (int i = 0; i < 6; i++) check_frame(i, p, 15);
        chk(din_bad == 0, "R4 data moved in high phase", din_bad, 0);
        chk(ovl_bad == 0, "R5 strobe with clock high", ovl_bad, 0);
        chk(en_bad == 0, "R7 grid enable in shift/strobe", en_bad, 0);
    endtask

    task automatic t_walk();
        logic [NG*NA-1:0] p = {31'h55555555, 31'h00000000, 31'h7FFFFFFF};
        start(p, 4'd8);
        wait_fin(3);
        for (int i = 0; i < 3; i++) check_frame(i, p, 8);
    endtask

    task automatic t_dim();
        logic [NG*NA-1:0] p = {31'h00F00F00, 31'h12345678, 31'h0C0FFEE0};
        int dv [3] = '{0, 1, 15};
        for (int n = 0; n < 3; n++) begin
            start(p, 4'(dv[n]));
            wait_fin(3);
            for (int i = 0; i < 3; i++) check_frame(i, p, dv[n]);
        end
        chk(en_bad == 0, "R7 grid enable in shift/strobe", en_bad, 0);
    endtask

    task automatic t_mid();
        logic [NG*NA-1:0] pa = {31'h11111111, 31'h22222222, 31'h33333333};
        logic [NG*NA-1:0] pb = {31'h7EDCBA98, 31'h01234567, 31'h76543210};
        int t = 0;
        start(pa, 4'd3);
        while (nfrm < 1 && t < 20000) begin @(negedge clk); t++; end
        pat = pb; duty = 4'd12;
        wait_fin(4);
        for (int i = 0; i < 3; i++) check_frame(i, pa, 3);
        check_frame(3, pb, 12); // R9 new data only at next scan
    endtask

    initial begin
        t_reset();
        t_basic();
        t_walk();
        t_dim();
        t_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule